// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence of one SDRAM burst, one column per clock. A read or write command loads a start column, a three-bit burst length code and an ordering select. The block then steps through the columns of the burst. It either counts upward and wraps inside the aligned block, or it XORs the start offset with the element index. The column width is the parameter `COL_W`, typically 9, 10 or 11 bits.

Finite bursts of 1, 2, 4 or 8 elements end by themselves and flag their final element. A full-page burst has no final element: it walks the whole page and wraps until a stop or a new command arrives. A new command in the middle of a burst drops the remaining columns and starts again at the new column with the full length. A clock-enable input that is held low freezes the generator in place, which models clock suspend. Data transfer and bank control belong to the surrounding controller.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `col_valid` and `col_last` are 0.
- R2: When `start` is sampled high while `ce` is high, the next cycle shows `col_valid`=1 and `col_out` equal to the sampled `start_col`. The length code and ordering select are captured in the same cycle.
- R3: Length codes `bl_code` 000, 001, 010 and 011 give bursts of 1, 2, 4 and 8 columns. The reserved codes 100, 101 and 110 give 1 column. After the last column, `col_valid` returns to 0 in the next cycle unless a new command has started.
- R4: With `interleave`=0 and a finite length N, element k keeps the column bits above log2(N) of the start column. Its low log2(N) bits equal (start low bits + k) mod N.
- R5: With `interleave`=1 and a finite length N, element k is the start column XOR k. For example, N=8 from column 2 gives 2,3,0,1,6,7,4,5.
- R6: Code 111 selects full page. Element k is (start_col + k) mod 2^COL_W, the burst never ends by itself, and `interleave` is ignored because full page is always sequential.
- R7: `col_last` is 1 exactly on the final element of a finite burst. It is never 1 during a full-page burst.
- R8: A `start` that arrives during a burst discards the remaining columns. It begins a new burst at the new column with the full length and the ordering of the new command.
- R9: A `stop` sampled with `ce` high ends the burst, so `col_valid` is 0 in the next cycle. If `start` and `stop` are high together, `start` wins.
- R10: While `ce` is low, `col_out`, `col_valid` and `col_last` hold their values, and `start` and `stop` are ignored. The sequence resumes with the next element once `ce` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; low freezes the generator |
| start | input | 1 | Read/write command: begin a burst |
| stop | input | 1 | Burst stop command |
| start_col | input | COL_W | First column of the burst |
| bl_code | input | 3 | Burst length code |
| interleave | input | 1 | 1 = interleaved (XOR) ordering, 0 = sequential |
| col_out | output | COL_W | Current column address |
| col_valid | output | 1 | `col_out` holds an element of an active burst |
| col_last | output | 1 | Current element is the final one of a finite burst |

## Verification
The checker covers the properties that hold on every cycle, checked at the ports:
- a command loads the start column in the next cycle;
- `col_valid` drops after the last element or after a stop;
- an element that is not final is always followed by another;
- all outputs are frozen while `ce` is low;
- `col_last` never appears without `col_valid`.

Only the bench scenarios can show that the column values follow the right ordering. The bench sweeps every start column, every length code and both orderings on a 6-bit column. It also runs full-page wrap, an interrupt that changes length and ordering, and commands issued during suspend.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    // Burst length codes; any other value acts as a single column.
    typedef enum logic [2:0] {
        BL_ONE   = 3'b000,
        BL_TWO   = 3'b001,
        BL_FOUR  = 3'b010,
        BL_EIGHT = 3'b011,
        BL_PAGE  = 3'b111
    } bl_code_e;

    // Captured configuration of the running burst.
    typedef struct packed {
        logic       full;      // full-page burst, no natural end
        logic       ilv;       // XOR ordering in effect
        logic [1:0] len_log2;  // log2 of finite length
    } burst_cfg_t;

    localparam int LEN_LOG2_MAX = 3;

    function automatic burst_cfg_t decode_cfg(input logic [2:0] code, input logic ilv_req);
        burst_cfg_t c;
        c.full     = 1'b0;
        c.len_log2 = 2'd0;
        case (code)
            BL_TWO:   c.len_log2 = 2'd1;
            BL_FOUR:  c.len_log2 = 2'd2;
            BL_EIGHT: c.len_log2 = 2'd3;
            BL_PAGE:  c.full     = 1'b1;
            default:  c.len_log2 = 2'd0;
        endcase
        // full page only runs sequentially
        c.ilv = ilv_req & ~c.full;
        return c;
    endfunction

endpackage

// File: rtl/bcg_mask_gen.sv
module bcg_mask_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  burst_cfg_t       cfg,
    output logic [COL_W-1:0] mask
);
    // A set mask bit marks a column bit that moves inside the burst block.
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        if (i < LEN_LOG2_MAX) begin : g_low
            assign mask[i] = cfg.full | ({30'd0, cfg.len_log2} > i);
        end else begin : g_high
            assign mask[i] = cfg.full;
        end
    end
endmodule

// File: rtl/bcg_step_ctr.sv
module bcg_step_ctr #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             start,
    input  logic             stop,
    input  logic             full,
    input  logic [COL_W-1:0] mask,
    output logic             active,
    output logic [COL_W-1:0] step,
    output logic             at_end
);
    logic             active_q;
    logic [COL_W-1:0] step_q;

    assign at_end = ~full & (step_q == mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            step_q   <= '0;
        end else if (ce) begin
            if (start) begin
                active_q <= 1'b1;
                step_q   <= '0;
            end else if (stop) begin
                active_q <= 1'b0;
            end else if (active_q) begin
                if (at_end) active_q <= 1'b0;
                else        step_q   <= step_q + 1'b1;
            end
        end
    end

    assign active = active_q;
    assign step   = step_q;
endmodule

// File: rtl/bcg_col_former.sv
module bcg_col_former #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] mask,
    input  logic [COL_W-1:0] step,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] xor_col;

    always_comb begin
        sum     = base + step;
        seq_col = (base & ~mask) | (sum & mask);
        xor_col = base ^ (step & mask);
        col     = ilv ? xor_col : seq_col;
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             start,
    input  logic             stop,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       bl_code,
    input  logic             interleave,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             col_last
);
    burst_cfg_t       cfg_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] step;
    logic             active;
    logic             at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            base_q <= '0;
        end else if (ce && start) begin
            cfg_q  <= decode_cfg(bl_code, interleave);
            base_q <= start_col;
        end
    end

    bcg_mask_gen #(.COL_W(COL_W)) u_mask (
        .cfg  (cfg_q),
        .mask (mask)
    );

    bcg_step_ctr #(.COL_W(COL_W)) u_step (
        .clk    (clk),
        .rst    (rst),
        .ce     (ce),
        .start  (start),
        .stop   (stop),
        .full   (cfg_q.full),
        .mask   (mask),
        .active (active),
        .step   (step),
        .at_end (at_end)
    );

    bcg_col_former #(.COL_W(COL_W)) u_form (
        .base (base_q),
        .mask (mask),
        .step (step),
        .ilv  (cfg_q.ilv),
        .col  (col_out)
    );

    assign col_valid = active;
    assign col_last  = active & at_end;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             ce,
    input logic             start,
    input logic             stop,
    input logic [COL_W-1:0] start_col,
    input logic [COL_W-1:0] col_out,
    input logic             col_valid,
    input logic             col_last
);
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        ce && start |=> col_valid && (col_out == $past(start_col)));

    p_end_r3: assert property (@(posedge clk) disable iff (rst)
        ce && !start && col_last |=> !col_valid);

    p_last_valid_r7: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_valid);

    p_stop_r9: assert property (@(posedge clk) disable iff (rst)
        ce && stop && !start |=> !col_valid);

    p_continue_r6: assert property (@(posedge clk) disable iff (rst)
        ce && !start && !stop && col_valid && !col_last |=> col_valid);

    p_freeze_r10: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(col_out) && $stable(col_valid) && $stable(col_last));
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce        (ce),
    .start     (start),
    .stop      (stop),
    .start_col (start_col),
    .col_out   (col_out),
    .col_valid (col_valid),
    .col_last  (col_last)
);

// File: tb/tb_burst_col_gen.sv
`timescale 1ns/1ps
module tb_burst_col_gen;
    localparam int CW = 6;
    localparam int PAGE = 1 << CW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce = 1'b1;
    logic          start = 1'b0;
    logic          stop = 1'b0;
    logic [CW-1:0] start_col = '0;
    logic [2:0]    bl_code = '0;
    logic          interleave = 1'b0;
    logic [CW-1:0] col_out;
    logic          col_valid;
    logic          col_last;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    burst_col_gen #(.COL_W(CW)) dut (
        .clk(clk), .rst(rst), .ce(ce), .start(start), .stop(stop),
        .start_col(start_col), .bl_code(bl_code), .interleave(interleave),
        .col_out(col_out), .col_valid(col_valid), .col_last(col_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int blen(input int code);
        return (code <= 3) ? (1 << code) : 1;
    endfunction

    function automatic int exp_col(input int s, input int code, input bit il, input int k);
        int n;
        if (code == 7) return (s + k) % PAGE;
        n = blen(code);
        if (il) return s ^ k;
        return (s & ~(n - 1)) | ((s + k) & (n - 1));
    endfunction

    // Issue a command; on return the first element is visible.
    task automatic cmd(input int s, input int code, input bit il, input bit with_stop);
        @(negedge clk);
        start = 1'b1; stop = with_stop; start_col = CW'(s);
        bl_code = 3'(code); interleave = il;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
    endtask

    // Check n elements from index k0 of the current burst.
    task automatic walk(input int s, input int code, input bit il, input int k0, input int n);
        string tag;
        int total;
        tag = (code == 7) ? "R6" : (il ? "R5" : "R4");
        total = blen(code);
        for (int k = k0; k < k0 + n; k++) begin
            chk(col_valid === 1'b1, "R3 valid", int'(col_valid), 1);
            chk(int'(col_out) == exp_col(s, code, il, k), tag, int'(col_out), exp_col(s, code, il, k));
            if (code == 7)
                chk(col_last === 1'b0, "R7 page", int'(col_last), 0);
            else
                chk(col_last === (k == total - 1), "R7", int'(col_last), int'(k == total - 1));
            if (k < k0 + n - 1) @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(col_valid === 1'b0, "R1 valid", int'(col_valid), 0);
        chk(col_last === 1'b0, "R1 last", int'(col_last), 0);

        // Exhaustive sweep of codes, orderings and start columns
        for (int code = 0; code < 8; code++) begin
            for (int il = 0; il < 2; il++) begin
                for (int s = 0; s < PAGE; s++) begin
                    cmd(s, code, il[0], 1'b0);
                    chk(int'(col_out) == s, "R2", int'(col_out), s);
                    if (code == 7) begin
                        walk(s, code, il[0], 0, PAGE + 6);
                        stop = 1'b1;
                        @(negedge clk);
                        stop = 1'b0;
                        chk(col_valid === 1'b0, "R9 stop page", int'(col_valid), 1'b0);
                    end else begin
                        walk(s, code, il[0], 0, blen(code));
                        @(negedge clk);
                        chk(col_valid === 1'b0, "R3 end", int'(col_valid), 0);
                    end
                end
            end
        end

        // R8: interrupt an 8-burst with an interleaved 4-burst
        cmd(5, 3, 1'b0, 1'b0);
        walk(5, 3, 1'b0, 0, 3);
        start = 1'b1; start_col = CW'(40); bl_code = 3'd2; interleave = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(int'(col_out) == 40, "R8 restart col", int'(col_out), 40);
        walk(40, 2, 1'b1, 0, 4);
        @(negedge clk);
        chk(col_valid === 1'b0, "R8 new length", int'(col_valid), 0);

        // R9: start and stop together -> start wins
        cmd(9, 1, 1'b0, 1'b1);
        chk(col_valid === 1'b1 && int'(col_out) == 9, "R9 start wins", int'(col_out), 9);
        walk(9, 1, 1'b0, 0, 2);
        // R9: stop in the middle of a finite burst
        cmd(8, 3, 1'b0, 1'b0);
        walk(8, 3, 1'b0, 0, 2);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(col_valid === 1'b0, "R9 mid stop", int'(col_valid), 0);

        // R10: suspend freezes and ignores commands
        cmd(16, 3, 1'b0, 1'b0);
        ce = 1'b0; start = 1'b1; start_col = CW'(50);
        repeat (2) begin
            @(negedge clk);
            chk(int'(col_out) == 16 && col_valid === 1'b1, "R10 start ignored", int'(col_out), 16);
        end
        start = 1'b0; stop = 1'b1;
        @(negedge clk);
        chk(int'(col_out) == 16 && col_valid === 1'b1, "R10 stop ignored", int'(col_out), 16);
        stop = 1'b0; ce = 1'b1;
        @(negedge clk);
        walk(16, 3, 1'b0, 1, 7);
        @(negedge clk);
        chk(col_valid === 1'b0, "R10 resume end", int'(col_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule